// File: doc/BRIEF.md
# Matrix Tile Reorder Unit

This block takes one matrix at a time as a stream of elements and hands it out again in a different order. In tiling mode a plain raster matrix becomes tile-major. The matrix is cut into small tiles of 2 or 4 rows by 2 or 4 columns. Each tile leaves row by row. Tiles follow each other left to right across a band of tile rows, and then the next band down is started. This is the layout a vector multiply engine wants. In untiling mode the block does the inverse: tile-major data goes in and plain raster data comes out.

A column-major flag says that the raster side of the conversion is column-major. In tiling mode this means the input arrives column by column. In untiling mode it means the output leaves column by column. Either way the matrix is transposed on its way through the block. The matrix size is fixed by parameters. Tile shape, mode and flag are inputs, captured with the first element of each matrix.

Two matrix buffers work as a ping-pong pair, so a new matrix can be written while the previous one is read out. A tile shape that does not divide the matrix evenly raises an error flag, and no new matrix is accepted while that flag is up.

Top module: `mtx_tile_reorder`

## Requirements
- R1: After reset, out_valid and out_last are 0, and in_ready is 1 while the configuration inputs are valid.
- R2: In tiling mode with a row-major input (untile=0, col_major=0), element (r,c) of the ROWS x COLS matrix arrives at raster position r*COLS+c. Output position k carries element (tr*TH+i, tc*TW+j). Here t=k/(TH*TW), tr=t/(COLS/TW), tc=t%(COLS/TW), i=(k%(TH*TW))/TW and j=k%TW.
- R3: Tile height TH is 4 when tile_h4=1 and 2 when tile_h4=0. Tile width TW is 4 when tile_w4=1 and 2 when tile_w4=0.
- R4: In tiling mode with col_major=1, input position k carries element (k%ROWS, k/ROWS). The output is the tile-major order of R2, so the matrix is transposed.
- R5: In untiling mode (untile=1), input position k carries the tile-major element of R2. The output is raster order: row-major (r*COLS+c) when col_major=0, and column-major (c*ROWS+r) when col_major=1.
- R6: cfg_err is 1 exactly when ROWS is not a multiple of TH or COLS is not a multiple of TW. While it is 1 and no matrix is partly written, in_ready is 0 and nothing is stored.
- R7: Mode, flag and tile shape are captured on the first accepted element of a matrix. Changes to them during the rest of that matrix have no effect on its output order.
- R8: While one matrix waits to be read, a second full matrix is accepted. in_ready falls to 0 only when both buffers hold unread matrices.
- R9: out_last is 1 on the final output element of each matrix and on no other element.
- R10: While out_valid=1 and out_ready=0, out_valid, out_data and out_last stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| untile | input | 1 | 0 = raster to tile-major, 1 = tile-major to raster |
| col_major | input | 1 | Raster side is column-major (transpose) |
| tile_h4 | input | 1 | Tile height: 1 = 4 rows, 0 = 2 rows |
| tile_w4 | input | 1 | Tile width: 1 = 4 columns, 0 = 2 columns |
| cfg_err | output | 1 | Tile shape does not divide the matrix |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted this cycle when valid |
| in_data | input | DW | Input element |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream takes the element |
| out_data | output | DW | Output element |
| out_last | output | 1 | Final element of a matrix |

## Verification
Some properties are checked on every cycle by the assertions. Both address generators must stay inside the matrix and must return to the origin after their last element. The output must hold still under backpressure. The mode must not change while a matrix is being written. The end marker must fall only on the element count that closes a matrix, and must always fall there. Some behaviour can only be shown by the bench scenarios. These are the actual permutations for each mode, flag and tile shape, the rejection of shapes that do not divide the matrix, capture of the configuration on the first element, and both buffers filling before the input stalls.

// File: rtl/mtx_reorder_pkg.sv
package mtx_reorder_pkg;

  typedef enum logic [1:0] {
    ORD_ROW  = 2'd0,
    ORD_COL  = 2'd1,
    ORD_TILE = 2'd2
  } ord_e;

  typedef struct packed {
    logic untile;
    logic cm;
    logic th4;
    logic tw4;
  } cfg_t;

  function automatic int tile_span(input logic sel4);
    return sel4 ? 4 : 2;
  endfunction

  function automatic int lin_addr(input int row, input int col, input int ncols);
    return row * ncols + col;
  endfunction

  function automatic logic shape_bad(input int rows, input int cols,
                                     input logic th4, input logic tw4);
    return ((rows % tile_span(th4)) != 0) || ((cols % tile_span(tw4)) != 0);
  endfunction

  function automatic ord_e write_order(input cfg_t c);
    if (c.untile) return ORD_TILE;
    return c.cm ? ORD_COL : ORD_ROW;
  endfunction

  function automatic ord_e read_order(input cfg_t c);
    if (!c.untile) return ORD_TILE;
    return c.cm ? ORD_COL : ORD_ROW;
  endfunction

endpackage

// File: rtl/mtx_order_gen.sv
module mtx_order_gen
  import mtx_reorder_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 6,
  localparam int N  = ROWS * COLS,
  localparam int AW = $clog2(N),
  localparam int CW = $clog2(((ROWS > COLS) ? ROWS : COLS) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  ord_e          kind,
  input  logic          th4,
  input  logic          tw4,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [CW-1:0] ir, ic, tr, tc;
  logic [CW-1:0] th_m1, tw_m1, ntr_m1, ntc_m1, row_max, col_max;
  logic [CW-1:0] row, col;
  logic          in_tile_end, band_end;

  assign row_max = CW'(ROWS - 1);
  assign col_max = CW'(COLS - 1);
  assign th_m1   = th4 ? CW'(3) : CW'(1);
  assign tw_m1   = tw4 ? CW'(3) : CW'(1);
  assign ntr_m1  = th4 ? CW'(ROWS / 4 - 1) : CW'(ROWS / 2 - 1);
  assign ntc_m1  = tw4 ? CW'(COLS / 4 - 1) : CW'(COLS / 2 - 1);

  assign in_tile_end = (ic == tw_m1) && (ir == th_m1);
  assign band_end    = in_tile_end && (tc == ntc_m1);

  always_comb begin
    if (kind == ORD_TILE) begin
      row  = (th4 ? (tr << 2) : (tr << 1)) + ir;
      col  = (tw4 ? (tc << 2) : (tc << 1)) + ic;
      last = band_end && (tr == ntr_m1);
    end else begin
      row  = ir;
      col  = ic;
      last = (ir == row_max) && (ic == col_max);
    end
  end

  assign addr = AW'(lin_addr(int'(row), int'(col), COLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir <= '0; ic <= '0; tr <= '0; tc <= '0;
    end else if (step) begin
      if (last) begin
        ir <= '0; ic <= '0; tr <= '0; tc <= '0;
      end else begin
        case (kind)
          ORD_ROW: begin
            if (ic == col_max) begin ic <= '0; ir <= ir + 1'b1; end
            else ic <= ic + 1'b1;
          end
          ORD_COL: begin
            if (ir == row_max) begin ir <= '0; ic <= ic + 1'b1; end
            else ir <= ir + 1'b1;
          end
          ORD_TILE: begin
            if (ic != tw_m1) ic <= ic + 1'b1;
            else begin
              ic <= '0;
              if (ir != th_m1) ir <= ir + 1'b1;
              else begin
                ir <= '0;
                if (tc != ntc_m1) tc <= tc + 1'b1;
                else begin tc <= '0; tr <= tr + 1'b1; end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(addr) < N); // R2
  AST_WRAP_TO_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    step && last |=> addr == '0); // R9

endmodule

// File: rtl/mtx_bank_mem.sv
module mtx_bank_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 96,
  localparam int MAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [MAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mtx_tile_reorder.sv
module mtx_tile_reorder
  import mtx_reorder_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 6,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          untile,
  input  logic          col_major,
  input  logic          tile_h4,
  input  logic          tile_w4,
  output logic          cfg_err,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);

  localparam int N   = ROWS * COLS;
  localparam int AW  = $clog2(N);
  localparam int MAW = $clog2(2 * N);

  cfg_t          live_cfg, held_cfg, wr_cfg, rd_cfg;
  cfg_t          bank_cfg [2];
  logic [1:0]    full;
  logic          wb, rb, w_active;
  logic          wr_first, wr_fire, wr_done, w_last;
  logic          rd_fire, rd_done, r_last;
  logic [AW-1:0] w_addr, r_addr;
  logic [MAW-1:0] mem_waddr, mem_raddr;
  ord_e          wr_kind, rd_kind;

  assign live_cfg = '{untile: untile, cm: col_major, th4: tile_h4, tw4: tile_w4};
  assign cfg_err  = shape_bad(ROWS, COLS, tile_h4, tile_w4);

  // write side
  assign wr_first = !w_active;
  assign wr_cfg   = wr_first ? live_cfg : held_cfg;
  assign wr_kind  = write_order(wr_cfg);
  assign in_ready = !full[wb] && !(wr_first && cfg_err);
  assign wr_fire  = in_valid && in_ready;
  assign wr_done  = wr_fire && w_last;

  mtx_order_gen #(.ROWS(ROWS), .COLS(COLS)) u_wr_gen (
    .clk(clk), .rst_n(rst_n), .step(wr_fire), .kind(wr_kind),
    .th4(wr_cfg.th4), .tw4(wr_cfg.tw4), .addr(w_addr), .last(w_last)
  );

  // read side
  assign rd_cfg    = bank_cfg[rb];
  assign rd_kind   = read_order(rd_cfg);
  assign out_valid = full[rb];
  assign rd_fire   = out_valid && out_ready;
  assign rd_done   = rd_fire && r_last;
  assign out_last  = out_valid && r_last;

  mtx_order_gen #(.ROWS(ROWS), .COLS(COLS)) u_rd_gen (
    .clk(clk), .rst_n(rst_n), .step(rd_fire), .kind(rd_kind),
    .th4(rd_cfg.th4), .tw4(rd_cfg.tw4), .addr(r_addr), .last(r_last)
  );

  assign mem_waddr = wb ? MAW'(N) + MAW'(w_addr) : MAW'(w_addr);
  assign mem_raddr = rb ? MAW'(N) + MAW'(r_addr) : MAW'(r_addr);

  mtx_bank_mem #(.DW(DW), .DEPTH(2 * N)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(mem_waddr), .wdata(in_data),
    .raddr(mem_raddr), .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb          <= 1'b0;
      rb          <= 1'b0;
      full        <= 2'b00;
      w_active    <= 1'b0;
      held_cfg    <= '0;
      bank_cfg[0] <= '0;
      bank_cfg[1] <= '0;
    end else begin
      if (wr_fire) begin
        if (wr_first) begin
          held_cfg     <= live_cfg;
          bank_cfg[wb] <= live_cfg;
        end
        w_active <= !w_last;
        if (w_last) begin
          full[wb] <= 1'b1;
          wb       <= ~wb;
        end
      end
      if (rd_done) begin
        full[rb] <= 1'b0;
        rb       <= ~rb;
      end
    end
  end

  // observation counter for the end-marker assertions
  logic [AW-1:0] o_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) o_cnt <= '0;
    else if (rd_fire) o_cnt <= (int'(o_cnt) == N - 1) ? '0 : o_cnt + 1'b1;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R10
  AST_LAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && out_last |-> int'(o_cnt) == N - 1); // R9
  AST_END_HAS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && int'(o_cnt) == N - 1 |-> out_last); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    w_active && $past(w_active) |-> wr_kind == $past(wr_kind)); // R7

endmodule

// File: tb/sim_mtx_tile_reorder.sv
module sim_mtx_tile_reorder;
  localparam int R  = 8;
  localparam int C  = 6;
  localparam int N  = R * C;
  localparam int DW = 16;

  // vector fields {untile, col_major, tile_h4, tile_w4, stall}
  localparam logic [4:0] VEC [0:5] = '{
    5'b00100,  // R2 R3 tile 4x2
    5'b00001,  // R2 R3 tile 2x2, stalled output
    5'b01100,  // R4 column-major in
    5'b10101,  // R5 untile 4x2, stalled
    5'b11000,  // R5 untile to column-major
    5'b10000   // R5 untile 2x2
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, b_untile, b_cm, b_h4, b_w4;
  logic in_valid, out_ready;
  logic [DW-1:0] in_data;
  logic cfg_err, in_ready, out_valid, out_last;
  logic [DW-1:0] out_data;

  mtx_tile_reorder #(.ROWS(R), .COLS(C), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .untile(b_untile), .col_major(b_cm),
    .tile_h4(b_h4), .tile_w4(b_w4), .cfg_err(cfg_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  int n_chk = 0;
  int n_fail = 0;
  int st_cnt = 0;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int val(input int seed, input int row, input int col);
    return (seed * 97 + row * C + col) % 65536;
  endfunction

  // kind 0 row-major, 1 column-major, 2 tile-major
  task automatic rc_of(input int kind, input int k, input int th, input int tw,
                       output int row, output int col);
    int t, w;
    if (kind == 0) begin row = k / C; col = k % C; end
    else if (kind == 1) begin row = k % R; col = k / R; end
    else begin
      t = k / (th * tw);
      w = k % (th * tw);
      row = (t / (C / tw)) * th + w / tw;
      col = (t % (C / tw)) * tw + w % tw;
    end
  endtask

  task automatic send(input int seed, input logic u, input logic cm,
                      input logic h4, input logic w4, input bit alt);
    int row, col, kind;
    kind = u ? 2 : (cm ? 1 : 0);
    b_untile = u; b_cm = cm; b_h4 = h4; b_w4 = w4;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      if (alt && k == 1) begin b_untile = ~u; b_cm = ~cm; b_h4 = ~h4; end
      rc_of(kind, k, h4 ? 4 : 2, w4 ? 4 : 2, row, col);
      in_valid = 1'b1;
      in_data  = DW'(val(seed, row, col));
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(input int seed, input logic u, input logic cm,
                      input logic h4, input logic w4, input bit stall, input string req);
    int row, col, kind, bad_d, bad_l, act_d, exp_d, at_l;
    kind = u ? (cm ? 1 : 0) : 2;
    bad_d = 0; bad_l = 0; act_d = 0; exp_d = 0; at_l = -1;
    for (int k = 0; k < N; k++) begin
      do begin
        @(negedge clk);
        if (stall) begin
          out_ready = ((st_cnt % 3) != 2);
          st_cnt++;
        end else out_ready = 1'b1;
      end while (!(out_valid && out_ready));
      rc_of(kind, k, h4 ? 4 : 2, w4 ? 4 : 2, row, col);
      if (int'(out_data) != val(seed, row, col) && bad_d == 0) begin
        bad_d = 1; act_d = int'(out_data); exp_d = val(seed, row, col);
      end
      if (out_last != (k == N - 1) && bad_l == 0) begin
        bad_l = 1; at_l = k;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk({req, " data order"}, bad_d == 0, act_d, exp_d);
    chk("R9 out_last position", bad_l == 0, at_l, N - 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    string req;
    rst_n = 1'b0; b_untile = 0; b_cm = 0; b_h4 = 0; b_w4 = 0;
    in_valid = 0; in_data = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0);
    chk("R1 out_last after reset", out_last == 1'b0, int'(out_last), 0);
    chk("R1 in_ready after reset", in_ready == 1'b1, int'(in_ready), 1);

    for (int v = 0; v < 6; v++) begin
      if (VEC[v][4]) req = "R5";
      else if (VEC[v][3]) req = "R4";
      else req = "R2 R3";
      fork
        send(v + 1, VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1], 1'b0);
        recv(v + 1, VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], req);
      join
    end

    // R6: tile width 4 does not divide 6 columns
    b_untile = 0; b_cm = 0; b_h4 = 1; b_w4 = 1;
    in_valid = 1'b1; in_data = 16'h1234;
    repeat (4) @(negedge clk);
    chk("R6 cfg_err for bad shape", cfg_err == 1'b1, int'(cfg_err), 1);
    chk("R6 in_ready blocked", in_ready == 1'b0, int'(in_ready), 0);
    chk("R6 nothing stored", out_valid == 1'b0, int'(out_valid), 0);
    in_valid = 1'b0;
    b_w4 = 0;
    @(negedge clk);
    chk("R6 cfg_err clear for good shape", cfg_err == 1'b0, int'(cfg_err), 0);
    chk("R6 in_ready back", in_ready == 1'b1, int'(in_ready), 1);

    // R7: configuration flipped after first element
    fork
      send(20, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      recv(20, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    join

    // R8: both banks filled with output held off
    out_ready = 1'b0;
    send(30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(31, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 in_ready low with both banks full", in_ready == 1'b0, int'(in_ready), 0);
    chk("R8 out_valid while full", out_valid == 1'b1, int'(out_valid), 1);
    recv(30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R8 first bank");
    recv(31, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 second bank");
    @(negedge clk);
    chk("R8 drained", out_valid == 1'b0 && in_ready == 1'b1, int'(out_valid), 0);

    finish_run();
  end

endmodule